// File: doc/BRIEF.md
# Dual Wiper Serial Control Interface

This block is the digital control logic for a two-channel digital potentiometer. A host drives a three-wire serial port made of an active-high enable, a serial clock and a data line. While the enable is high, each rising serial clock edge moves one data bit into a 17-bit frame register. One frame holds a stack-select flag and two 8-bit wiper codes. The registered wiper codes and the stack flag, which feed the analog switches, take new values only when the enable line falls. A wiper code therefore never changes in the middle of a transfer.

The serial pins are asynchronous to the chip. They are oversampled by the block's system clock through a configurable synchronizer, and the edges of the serial clock and of the enable are found in the system clock domain. When the enable rises, the frame register is loaded with the current settings. The bit at the far end of the register is driven onto a serial output on every falling serial clock edge. That output does two jobs. It reads back the old settings while a new frame is shifted in, and it passes bits on to a downstream device on the same bus, so N chained devices are loaded by one frame of 17×N bits.

Top module: `pot_wiper_ctrl`

## Requirements
- R1: After reset, both wiper outputs are 8'h80, the stack flag is 0, `serDout` is 0 and `serDoutEn` is 0.
- R2: Serial clock edges that arrive while `serEn` is low leave the wipers, the stack flag and `serDoutEn` unchanged.
- R3: A complete frame is sent as 17 bits in this order: the stack flag first, then the wiper1 code MSB first, then the wiper0 code MSB first. When `serEn` falls, the last 17 bits received become the new stack flag, wiper1 and wiper0 values.
- R4: `wiper0`, `wiper1` and `stackSel` change only after a falling edge of `serEn`, never during a transfer.
- R5: A transfer with fewer than 17 clocks is still applied. The frame register, loaded with the old settings in frame order, is shifted by the received bits, and the misaligned result is latched. A transfer with no clocks leaves every setting unchanged.
- R6: After `serEn` rises, `serDout` first shows the current stack flag. After each falling serial clock edge it shows the next bit of the current settings, in frame order.
- R7: A bit sampled on rising serial edge k appears on `serDout` after falling edge k+16, so a downstream device samples it on rising edge k+17. With a 34-bit transfer the device keeps the last 17 bits and passes the first 17 bits on.
- R8: `serDoutEn` is high from the detected rise of `serEn` until its detected fall, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| serEn | input | 1 | Serial port enable, active high |
| serClk | input | 1 | Serial clock; data is sampled on its rising edge |
| serDin | input | 1 | Serial data in |
| wiper0 | output | 8 | Registered wiper 0 position |
| wiper1 | output | 8 | Registered wiper 1 position |
| stackSel | output | 1 | Registered stack-select flag |
| serDout | output | 1 | Readback and cascade data, updated after falling serial edges |
| serDoutEn | output | 1 | Output enable for `serDout` |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock. Every high or low phase of `serClk` and `serEn` must last longer than the synchronizer depth plus one system cycle. `serDin` must be steady across each rising serial edge, and `serEn` must not toggle in the same system cycle as `serClk`. The bench holds each serial phase for eight system clocks. It changes data only while the serial clock is low and keeps a full half-bit gap around each enable transition, so every detected edge is clean and the strobes are mutually exclusive.

// File: rtl/pot_pkg.sv
package pot_pkg;
  // One-cycle strobes produced by the control path.
  typedef struct packed {
    logic preload;  // enable rose: load current settings into the frame register
    logic shift;    // serial clock rose while enabled
    logic drive;    // serial clock fell while enabled
    logic latch;    // enable fell: apply frame register
  } potStrobe_t;
endpackage

// File: rtl/pot_ctrl.sv
module pot_ctrl
  import pot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serEn,
  input  logic       serClk,
  input  logic       serDin,
  output logic       dinSync,
  output potStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] enPipe, clkPipe, dinPipe;
  logic enNow, clkNow, enPrev, clkPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enPipe  <= '0;
          clkPipe <= '0;
          dinPipe <= '0;
        end else begin
          enPipe  <= serEn;
          clkPipe <= serClk;
          dinPipe <= serDin;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enPipe  <= '0;
          clkPipe <= '0;
          dinPipe <= '0;
        end else begin
          enPipe  <= {enPipe[LAST-1:0], serEn};
          clkPipe <= {clkPipe[LAST-1:0], serClk};
          dinPipe <= {dinPipe[LAST-1:0], serDin};
        end
      end
    end
  endgenerate

  assign enNow   = enPipe[LAST];
  assign clkNow  = clkPipe[LAST];
  assign dinSync = dinPipe[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      clkPrev <= 1'b0;
    end else begin
      enPrev  <= enNow;
      clkPrev <= clkNow;
    end
  end

  always_comb begin
    strobe.preload = enNow & ~enPrev;
    strobe.latch   = ~enNow & enPrev;
    strobe.shift   = clkNow & ~clkPrev & enNow & enPrev;
    strobe.drive   = ~clkNow & clkPrev & enNow & enPrev;
  end

  // A latch never coincides with a shift or any other strobe.
  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.preload, strobe.shift, strobe.drive, strobe.latch}));
endmodule

// File: rtl/pot_datapath.sv
module pot_datapath
  import pot_pkg::*;
#(
  parameter int WIPER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  potStrobe_t         strobe,
  input  logic               dinSync,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1,
  output logic               stackSel,
  output logic               serDout,
  output logic               serDoutEn
);
  localparam int FRAME_W = 2 * WIPER_W + 1;
  localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1) << (WIPER_W - 1);

  logic [FRAME_W-1:0] shiftReg, preloadVec;
  logic [WIPER_W-1:0] wiper0Reg, wiper1Reg, nextW0, nextW1;
  logic stackReg, outBit, outEn;

  // Frame position 0 is the stack flag; each wiper field is MSB first.
  assign preloadVec[0] = stackReg;
  generate
    for (genvar i = 0; i < WIPER_W; i++) begin : g_map
      assign preloadVec[1 + i]           = wiper1Reg[WIPER_W-1-i];
      assign preloadVec[1 + WIPER_W + i] = wiper0Reg[WIPER_W-1-i];
      assign nextW1[WIPER_W-1-i]         = shiftReg[1 + i];
      assign nextW0[WIPER_W-1-i]         = shiftReg[1 + WIPER_W + i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.preload) begin
      shiftReg <= preloadVec;
    end else if (strobe.shift) begin
      shiftReg <= {dinSync, shiftReg[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wiper0Reg <= MIDSCALE;
      wiper1Reg <= MIDSCALE;
      stackReg  <= 1'b0;
    end else if (strobe.latch) begin
      wiper0Reg <= nextW0;
      wiper1Reg <= nextW1;
      stackReg  <= shiftReg[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBit <= 1'b0;
      outEn  <= 1'b0;
    end else begin
      if (strobe.preload)    outBit <= preloadVec[0];
      else if (strobe.drive) outBit <= shiftReg[0];
      if (strobe.preload)    outEn <= 1'b1;
      else if (strobe.latch) outEn <= 1'b0;
    end
  end

  assign wiper0    = wiper0Reg;
  assign wiper1    = wiper1Reg;
  assign stackSel  = stackReg;
  assign serDout   = outBit;
  assign serDoutEn = outEn;

  assert_hold_settings_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latch |=> $stable({wiper0Reg, wiper1Reg, stackReg}));

  assert_latch_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> (stackReg == $past(shiftReg[0])
                      && wiper1Reg[WIPER_W-1] == $past(shiftReg[1])
                      && wiper0Reg[0] == $past(shiftReg[FRAME_W-1])));

  assert_idle_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.shift || strobe.preload) |=> $stable(shiftReg));

  assert_preload_stack_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.preload |=> (shiftReg[0] == $past(stackReg) && outEn));
endmodule

// File: rtl/pot_wiper_ctrl.sv
module pot_wiper_ctrl
  import pot_pkg::*;
#(
  parameter int WIPER_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serEn,
  input  logic               serClk,
  input  logic               serDin,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1,
  output logic               stackSel,
  output logic               serDout,
  output logic               serDoutEn
);
  potStrobe_t strobe;
  logic dinSync;

  pot_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serEn  (serEn),
    .serClk (serClk),
    .serDin (serDin),
    .dinSync(dinSync),
    .strobe (strobe)
  );

  pot_datapath #(.WIPER_W(WIPER_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dinSync  (dinSync),
    .wiper0   (wiper0),
    .wiper1   (wiper1),
    .stackSel (stackSel),
    .serDout  (serDout),
    .serDoutEn(serDoutEn)
  );
endmodule

// File: tb/pot_wiper_ctrl_tb.sv
`timescale 1ns/1ps
module pot_wiper_ctrl_tb;
  localparam int HALF = 8;
  localparam int NVEC = 5;
  // Frame encoding: {stack, wiper1, wiper0}; bit 16 is sent first.
  localparam logic [16:0] VECS [NVEC] = '{
    {1'b1, 8'hA5, 8'h3C},
    {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h00, 8'hFF},
    {1'b0, 8'h81, 8'h7E},
    {1'b1, 8'h12, 8'hC9}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic serEn = 1'b0, serClk = 1'b0, serDin = 1'b0;
  logic [7:0] wiper0, wiper1;
  logic stackSel, serDout, serDoutEn;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pot_wiper_ctrl u_dut (
    .clk(clk), .rstN(rstN), .serEn(serEn), .serClk(serClk), .serDin(serDin),
    .wiper0(wiper0), .wiper1(wiper1), .stackSel(stackSel),
    .serDout(serDout), .serDoutEn(serDoutEn)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] rev17(input logic [16:0] v);
    logic [16:0] r;
    for (int i = 0; i < 17; i++) r[i] = v[16-i];
    return r;
  endfunction

  task automatic sendBit(input logic b, output logic seen);
    serDin = b;
    waitClk(HALF);
    seen = serDout;
    serClk = 1'b1;
    waitClk(HALF);
    serClk = 1'b0;
    waitClk(HALF);
  endtask

  task automatic beginTxn();
    serEn = 1'b1;
    waitClk(HALF);
  endtask

  task automatic endTxn();
    serEn = 1'b0;
    waitClk(HALF);
  endtask

  task automatic checkSettings(input string req, input logic [16:0] f);
    check(req, {31'd0, stackSel}, {31'd0, f[16]});
    check(req, {24'd0, wiper1}, {24'd0, f[15:8]});
    check(req, {24'd0, wiper0}, {24'd0, f[7:0]});
  endtask

  initial begin
    logic [16:0] cur, model, fa, fb;
    logic seen;
    logic [4:0] shortBits;
    waitClk(4);
    // R1 reset state
    check("R1 wiper0", {24'd0, wiper0}, 32'h80);
    check("R1 wiper1", {24'd0, wiper1}, 32'h80);
    check("R1 stack", {31'd0, stackSel}, 32'd0);
    check("R1 serDout", {31'd0, serDout}, 32'd0);
    check("R1 serDoutEn", {31'd0, serDoutEn}, 32'd0);
    rstN = 1'b1;
    waitClk(4);
    cur = {1'b0, 8'h80, 8'h80};

    // Table walk: R3 load, R6 readback of previous settings, R4 and R8
    for (int v = 0; v < NVEC; v++) begin
      beginTxn();
      check("R8 enable high", {31'd0, serDoutEn}, 32'd1);
      for (int j = 0; j < 17; j++) begin
        sendBit(VECS[v][16-j], seen);
        check("R6 readback bit", {31'd0, seen}, {31'd0, cur[16-j]});
      end
      checkSettings("R4 unchanged before release", cur);
      endTxn();
      checkSettings("R3 frame applied", VECS[v]);
      check("R8 enable low", {31'd0, serDoutEn}, 32'd0);
      cur = VECS[v];
      waitClk(HALF);
    end

    // R2: clocks with enable low are ignored
    for (int j = 0; j < 17; j++) sendBit(1'b1, seen);
    checkSettings("R2 ignored clocks", cur);
    check("R2 enable stays low", {31'd0, serDoutEn}, 32'd0);

    // R5: enable pulse without clocks keeps everything
    beginTxn();
    endTxn();
    checkSettings("R5 empty transfer", cur);
    waitClk(HALF);

    // R5: short transfer of 5 bits is applied misaligned
    shortBits = 5'b10110;
    model = rev17(cur);
    beginTxn();
    for (int j = 0; j < 5; j++) begin
      sendBit(shortBits[j], seen);
      model = {shortBits[j], model[16:1]};
    end
    endTxn();
    cur = rev17(model);
    checkSettings("R5 short transfer", cur);
    waitClk(HALF);

    // R7: 34-bit cascade transfer
    fa = {1'b1, 8'h5A, 8'hE7};
    fb = {1'b0, 8'h96, 8'h1F};
    beginTxn();
    for (int m = 0; m < 34; m++) begin
      logic b, expOut;
      b = (m < 17) ? fa[16-m] : fb[16-(m-17)];
      if (m < 17) expOut = cur[16-m];
      else expOut = fa[16-(m-17)];
      sendBit(b, seen);
      check(m < 17 ? "R6 cascade readback" : "R7 cascade passthrough",
            {31'd0, seen}, {31'd0, expOut});
    end
    endTxn();
    checkSettings("R7 keeps last frame", fb);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule